// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. A free-running enable, `os_tick`, pulses sixteen times per bit period and is the only time base the receiver uses. The raw line is first passed through a two-flop synchronizer. The receiver then waits for the line to go low and confirms the start bit half a bit later. After that it samples every following bit at its centre, assembles the data least significant bit first, and checks parity and the first stop bit. The character format is chosen at run time: 5 to 8 data bits, and parity that is none, even, odd, forced one (mark) or forced zero (space). Any stop length the transmitter uses is accepted, because only one stop bit is needed before the next start can be detected.

Each received character leaves the block on a valid/ready stream together with its parity and framing flags. The serial line cannot be paused, so the stream offers no real back-pressure. `rx_valid` stays high, and the word and its flags stay constant, until the consumer raises `rx_ready`. The word is taken on any clock edge where both signals are high. If another character completes before the pending word has been taken, the new character replaces it and `rx_overrun` is set on the new word. Only data bits are delivered. Start, parity and stop bits are never stored.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_parity_err`, `rx_frame_err` and `rx_overrun` are all low, and the line is treated as idle-high.
- R2: With `cfg_len`=3 (8 data bits), the first data bit after the start bit is placed in `rx_data[0]` and the last in `rx_data[7]`.
- R3: `cfg_len` selects 5+`cfg_len` data bits. For 5, 6 or 7 bits, the unused upper bits of `rx_data` read zero.
- R4: `cfg_par` encodes 0=none, 1=even, 2=odd, 3=mark, 4=space; codes 5 to 7 act as none. Under even or odd parity, `rx_parity_err` is set when the count of ones over the data bits and the parity bit is not even (even mode) or not odd (odd mode). Start and stop bits are excluded from the count. With no parity, the flag stays low and no parity bit is expected.
- R5: Under mark or space parity, `rx_parity_err` is set when the received parity bit is not 1 (mark) or not 0 (space), whatever the data.
- R6: A low pulse that has ended by the centre of the start bit (8 ticks after it was detected) produces no character, and the receiver returns to idle.
- R7: A low first stop bit sets `rx_frame_err` on the delivered character. After that, no new start is detected until the line has been seen high.
- R8: A start bit that begins right after a single stop bit is received correctly, so back-to-back characters are not lost.
- R9: When a character completes while the previous word is still valid and not being taken, the new word replaces it and `rx_overrun` is set with it.
- R10: `rx_valid`, `rx_data` and the flags stay stable until a cycle with `rx_ready` high. `rx_valid` then drops on the next edge, unless a new character lands in that same cycle.
- R11: The receiver advances only on cycles where `os_tick` is high. With `os_tick` held low, a full character on the line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd | input | 1 | Raw serial line, idle high |
| cfg_len | input | 2 | Data length select: 5+value bits |
| cfg_par | input | 3 | Parity mode: 0 none, 1 even, 2 odd, 3 mark, 4 space |
| rx_data | output | 8 | Received data word, right-aligned |
| rx_valid | output | 1 | Word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_parity_err | output | 1 | Parity mismatch for this word |
| rx_frame_err | output | 1 | First stop bit was low for this word |
| rx_overrun | output | 1 | This word replaced an untaken word |

## Verification
The bench uses the default parameters: 16 ticks per bit, an 8-bit maximum word and a 5-bit minimum. This covers every length setting and all five parity modes. Most tests pulse `os_tick` on every clock, so a bit lasts 16 clocks and the centre sampling, glitch rejection and back-to-back timing are exercised at their tightest. One test halves the tick rate and another holds the tick low, to show that `os_tick` alone sets the pace.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  function automatic logic par_expects_bit(input logic [2:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
           (mode == PAR_MARK) || (mode == PAR_SPACE);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic synced
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 8,
  parameter int DATA_MIN = 5,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                line,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                par_en,
  output logic [DATA_MAX-1:0] word,
  output logic                par_bit,
  output logic                done,
  output logic                frame_err
);

  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int IDX_W = $clog2(DATA_MAX + 1);

  rx_state_e             state;
  logic [CNT_W-1:0]      tcnt;
  logic [IDX_W-1:0]      bidx;
  logic [DATA_MAX-1:0]   shreg;
  logic [IDX_W-1:0]      last_idx;
  logic [IDX_W-1:0]      align_sh;
  logic                  at_half;
  logic                  at_full;

  assign last_idx = IDX_W'(DATA_MIN - 1) + IDX_W'(cfg_len);
  assign align_sh = IDX_W'(DATA_MAX - 1) - last_idx;
  assign at_half  = (tcnt == CNT_W'(HALF - 1));
  assign at_full  = (tcnt == CNT_W'(OSR - 1));
  assign word     = shreg >> align_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      done      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            tcnt <= '0;
            if (!line) state <= ST_START;
          end
          ST_START: begin
            if (at_half) begin
              tcnt <= '0;
              bidx <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_full) begin
              tcnt  <= '0;
              shreg <= {line, shreg[DATA_MAX-1:1]};
              if (bidx == last_idx) begin
                state <= par_en ? ST_PAR : ST_STOP;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_full) begin
              tcnt    <= '0;
              par_bit <= line;
              state   <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_full) begin
              tcnt      <= '0;
              done      <= 1'b1;
              frame_err <= !line;
              state     <= line ? ST_IDLE : ST_WAITHI;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_WAITHI: begin
            tcnt <= '0;
            if (line) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_parity_eval.sv
module rx_parity_eval
  import serial_rx_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic [DATA_MAX-1:0] word,
  input  logic                par_bit,
  input  logic [2:0]          mode,
  output logic                err
);

  logic ones_odd;
  assign ones_odd = ^{word, par_bit};

  always_comb begin
    unique case (mode)
      PAR_EVEN:  err = ones_odd;
      PAR_ODD:   err = !ones_odd;
      PAR_MARK:  err = !par_bit;
      PAR_SPACE: err = par_bit;
      default:   err = 1'b0;
    endcase
  end

endmodule

// File: rtl/rx_word_hold.sv
module rx_word_hold #(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                in_perr,
  input  logic                in_ferr,
  input  logic                ready,
  output logic [DATA_MAX-1:0] data,
  output logic                valid,
  output logic                perr,
  output logic                ferr,
  output logic                ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load) begin
      data  <= in_data;
      valid <= 1'b1;
      perr  <= in_perr;
      ferr  <= in_ferr;
      ovr   <= valid && !ready;
    end else if (valid && ready) begin
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_MAX    = 8,
  parameter int DATA_MIN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      os_tick,
  input  logic                                      rxd,
  input  logic [$clog2(DATA_MAX-DATA_MIN+1)-1:0]    cfg_len,
  input  logic [2:0]                                cfg_par,
  output logic [DATA_MAX-1:0]                       rx_data,
  output logic                                      rx_valid,
  input  logic                                      rx_ready,
  output logic                                      rx_parity_err,
  output logic                                      rx_frame_err,
  output logic                                      rx_overrun
);

  localparam int LEN_W = $clog2(DATA_MAX - DATA_MIN + 1);

  logic                line_s;
  logic [DATA_MAX-1:0] word;
  logic                par_bit;
  logic                char_done;
  logic                stop_bad;
  logic                par_bad;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (rxd),
    .synced (line_s)
  );

  rx_frame_engine #(
    .OSR(OSR), .DATA_MAX(DATA_MAX), .DATA_MIN(DATA_MIN), .LEN_W(LEN_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .line      (line_s),
    .cfg_len   (cfg_len),
    .par_en    (par_expects_bit(cfg_par)),
    .word      (word),
    .par_bit   (par_bit),
    .done      (char_done),
    .frame_err (stop_bad)
  );

  rx_parity_eval #(.DATA_MAX(DATA_MAX)) u_par (
    .word    (word),
    .par_bit (par_bit),
    .mode    (cfg_par),
    .err     (par_bad)
  );

  rx_word_hold #(.DATA_MAX(DATA_MAX)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (char_done),
    .in_data (word),
    .in_perr (par_bad),
    .in_ferr (stop_bad),
    .ready   (rx_ready),
    .data    (rx_data),
    .valid   (rx_valid),
    .perr    (rx_parity_err),
    .ferr    (rx_frame_err),
    .ovr     (rx_overrun)
  );

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DATA_MAX = 8,
  parameter int DATA_MIN = 5,
  parameter int LEN_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_valid,
  input logic                rx_ready,
  input logic [DATA_MAX-1:0] rx_data,
  input logic                rx_overrun,
  input logic                rx_parity_err,
  input logic [2:0]          cfg_par,
  input logic [LEN_W-1:0]    cfg_len,
  input logic                char_done
);

  assert_valid_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  assert_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !char_done |=> $stable(rx_data));

  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !char_done |=> !rx_valid);

  assert_overrun_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);

  assert_no_parity_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (cfg_par == 3'd0) |-> !rx_parity_err);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (cfg_len == '0) |-> ((rx_data >> DATA_MIN) == '0));

endmodule

bind serial_rx_core serial_rx_core_chk #(
  .DATA_MAX(DATA_MAX), .DATA_MIN(DATA_MIN), .LEN_W(LEN_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .rx_ready      (rx_ready),
  .rx_data       (rx_data),
  .rx_overrun    (rx_overrun),
  .rx_parity_err (rx_parity_err),
  .cfg_par       (cfg_par),
  .cfg_len       (cfg_len),
  .char_done     (char_done)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       rx_parity_err;
  logic       rx_frame_err;
  logic       rx_overrun;

  int  checks = 0;
  int  fails  = 0;
  int  tick_div = 1;
  int  bitc = OSR;
  logic tick_ph = 1'b0;
  int  cycles = 0;

  int         cap_count = 0;
  logic [7:0] cap_data;
  logic       cap_pe, cap_fe, cap_ov;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
  );

  always @(negedge clk) tick_ph <= ~tick_ph;
  assign os_tick = (tick_div == 0) ? 1'b0 : (tick_div == 1) ? 1'b1 : tick_ph;

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      cap_count <= cap_count + 1;
      cap_data  <= rx_data;
      cap_pe    <= rx_parity_err;
      cap_fe    <= rx_frame_err;
      cap_ov    <= rx_overrun;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic [2:0] pm);
    logic [7:0] m;
    m = d & 8'((1 << nb) - 1);
    case (pm)
      3'd1: return ^m;
      3'd2: return ~(^m);
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive_bit(input logic v, input int ncyc);
    rxd = v;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int nb, input logic [2:0] pm,
                           input bit bad_par, input logic stop_v, input int stop_cyc);
    drive_bit(1'b0, bitc);
    for (int i = 0; i < nb; i++) drive_bit(d[i], bitc);
    if (pm >= 3'd1 && pm <= 3'd4) drive_bit(par_of(d, nb, pm) ^ bad_par, bitc);
    drive_bit(stop_v, stop_cyc);
    rxd = 1'b1;
  endtask

  task automatic expect_char(input string req, input int base, input logic [7:0] ed,
                             input logic epe, input logic efe);
    repeat (4) @(negedge clk);
    check({req, " count"}, cap_count, base + 1);
    check({req, " data"}, cap_data, ed);
    check({req, " parity flag"}, cap_pe, epe);
    check({req, " frame flag"}, cap_fe, efe);
    check({req, " overrun flag"}, cap_ov, 1'b0);
  endtask

  task automatic one_char(input string req, input logic [7:0] d, input int nb,
                          input logic [2:0] pm, input bit bad, input logic [7:0] ed,
                          input logic epe);
    int base;
    base = cap_count;
    cfg_len = 2'(nb - 5);
    cfg_par = pm;
    send_char(d, nb, pm, bad, 1'b1, bitc);
    expect_char(req, base, ed, epe, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 valid", rx_valid, 0);
    check("R1 parity flag", rx_parity_err, 0);
    check("R1 frame flag", rx_frame_err, 0);
    check("R1 overrun flag", rx_overrun, 0);
  endtask

  task automatic t_eight();
    one_char("R2 A5", 8'hA5, 8, 3'd0, 0, 8'hA5, 0);
    one_char("R2 01", 8'h01, 8, 3'd0, 0, 8'h01, 0);
    one_char("R2 80", 8'h80, 8, 3'd0, 0, 8'h80, 0);
  endtask

  task automatic t_short();
    one_char("R3 5bit", 8'hFF, 5, 3'd0, 0, 8'h1F, 0);
    one_char("R3 6bit", 8'hEA, 6, 3'd0, 0, 8'h2A, 0);
    one_char("R3 7bit", 8'hD5, 7, 3'd0, 0, 8'h55, 0);
  endtask

  task automatic t_parity();
    one_char("R4 even ok", 8'h37, 8, 3'd1, 0, 8'h37, 0);
    one_char("R4 even bad", 8'h37, 8, 3'd1, 1, 8'h37, 1);
    one_char("R4 odd ok", 8'h5C, 7, 3'd2, 0, 8'h5C, 0);
    one_char("R4 odd bad", 8'h5C, 7, 3'd2, 1, 8'h5C, 1);
    one_char("R4 code7 none", 8'h3C, 8, 3'd7, 0, 8'h3C, 0);
  endtask

  task automatic t_markspace();
    one_char("R5 mark ok", 8'h41, 7, 3'd3, 0, 8'h41, 0);
    one_char("R5 mark bad", 8'h41, 7, 3'd3, 1, 8'h41, 1);
    one_char("R5 space ok", 8'h7E, 7, 3'd4, 0, 8'h7E, 0);
    one_char("R5 space bad", 8'h7E, 7, 3'd4, 1, 8'h7E, 1);
  endtask

  task automatic t_glitch();
    int base;
    base = cap_count;
    cfg_len = 2'd3; cfg_par = 3'd0;
    drive_bit(1'b0, 4);
    drive_bit(1'b1, 3 * bitc);
    check("R6 no char from glitch", cap_count, base);
    one_char("R6 after glitch", 8'hC3, 8, 3'd0, 0, 8'hC3, 0);
  endtask

  task automatic t_frame();
    int base;
    base = cap_count;
    cfg_len = 2'd3; cfg_par = 3'd0;
    send_char(8'h99, 8, 3'd0, 0, 1'b0, bitc);
    drive_bit(1'b0, 3 * bitc);
    repeat (2) @(negedge clk);
    check("R7 count", cap_count, base + 1);
    check("R7 data", cap_data, 8'h99);
    check("R7 frame flag", cap_fe, 1);
    check("R7 no start while low", cap_count, base + 1);
    drive_bit(1'b1, bitc);
    one_char("R7 recover", 8'h5A, 8, 3'd0, 0, 8'h5A, 0);
  endtask

  task automatic t_b2b();
    int base;
    base = cap_count;
    cfg_len = 2'd3; cfg_par = 3'd1;
    send_char(8'h12, 8, 3'd1, 0, 1'b1, bitc);
    send_char(8'hED, 8, 3'd1, 0, 1'b1, bitc);
    expect_char("R8 second", base + 1, 8'hED, 0, 0);
    send_char(8'h0F, 8, 3'd1, 0, 1'b1, 2 * bitc);
    expect_char("R8 two stop", base + 2, 8'h0F, 0, 0);
    send_char(8'hF0, 8, 3'd1, 0, 1'b1, (3 * bitc) / 2);
    expect_char("R8 1.5 stop", base + 3, 8'hF0, 0, 0);
  endtask

  task automatic t_overrun();
    int base;
    base = cap_count;
    cfg_len = 2'd3; cfg_par = 3'd0;
    rx_ready = 1'b0;
    send_char(8'hAA, 8, 3'd0, 0, 1'b1, bitc);
    repeat (4) @(negedge clk);
    check("R10 held valid", rx_valid, 1);
    check("R10 held data", rx_data, 8'hAA);
    check("R10 no overrun yet", rx_overrun, 0);
    send_char(8'h55, 8, 3'd0, 0, 1'b1, bitc);
    repeat (4) @(negedge clk);
    check("R9 valid", rx_valid, 1);
    check("R9 newer data", rx_data, 8'h55);
    check("R9 overrun flag", rx_overrun, 1);
    check("R10 none taken", cap_count, base);
    rx_ready = 1'b1;
    @(negedge clk);
    check("R10 valid dropped", rx_valid, 0);
    check("R10 taken once", cap_count, base + 1);
    check("R9 taken overrun", cap_ov, 1);
  endtask

  task automatic t_tick();
    int base;
    tick_div = 0;
    base = cap_count;
    cfg_len = 2'd3; cfg_par = 3'd0;
    send_char(8'h00, 8, 3'd0, 0, 1'b1, bitc);
    drive_bit(1'b1, bitc);
    check("R11 ignored without tick", cap_count, base);
    tick_div = 2;
    bitc = 2 * OSR;
    drive_bit(1'b1, bitc);
    one_char("R11 half rate", 8'h96, 8, 3'd2, 0, 8'h96, 0);
    tick_div = 1;
    bitc = OSR;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_eight();
    t_short();
    t_parity();
    t_markspace();
    t_glitch();
    t_frame();
    t_b2b();
    t_overrun();
    t_tick();
    summary();
  end

endmodule